// File: doc/BRIEF.md
# Single-Device Line Dispatcher

This block takes whole cache-line read and write requests and sends every line to exactly one of eight narrow memory devices. Each device owns a private byte-wide data lane. Because the devices are independent, different devices can work on different lines at the same time, while devices with no work stay quiet and report themselves idle.

The request address is split into a device number, a bank and a row. The chosen device gets an activate command, then a column command after a fixed delay. The 64-byte line then crosses that device's lane in 64 consecutive beats, and a precharge closes the row. No row is ever left open, so there are no row hits. If a request targets a device that is already working, it waits in that device's own small queue. When that queue is full, the request port holds the request back.

Top module: `line_dispatch`

## Requirements
- R1: Address bits [5:0] are ignored. Bits [8:6] select the device, bits [10:9] give the bank and bits [23:11] give the row. The activate command carries that bank and row.
- R2: Commands for a request go only to the selected device. The other devices keep issuing code 0 (no-op). Command codes are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge.
- R3: The column command follows the activate exactly T_RCD cycles later.
- R4: The column command is write (3) for a write request and read (2) for a read request.
- R5: For a write, the lane enable is high for the 64 cycles after the write command. In beat k the lane carries byte k of the line, where byte k is write-data bits [8k+7:8k]. Byte 0 goes first.
- R6: For a read, the lane input is sampled in each of the 64 cycles after the read command. Each sampled byte comes out one cycle later on that device's response byte, with response valid high, in beat order.
- R7: A precharge with the same bank and row is issued 65 cycles after the column command. Every access closes its row.
- R8: A device issues no activate within T_RP cycles of its precharge. If a request is already waiting at the precharge, the next activate comes exactly T_RP cycles after it.
- R9: Each device queues up to 4 waiting requests. The request ready output is low while the addressed device's queue is full. Accepted requests are served in order and none are lost.
- R10: Devices run independently. A full queue on one device does not block requests to another, and several devices can transfer at the same time.
- R11: Device idle is high exactly when that device has no access in progress and an empty queue. After reset, all devices are idle, ready is high, and all commands, lane enables and response valids are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address of the line |
| req_wdata | input | 512 | Line data for writes, byte 0 in bits [7:0] |
| dev_cmd | output | 24 | 3-bit command per device, device d at [3d+2:3d] |
| dev_bank | output | 16 | 2-bit bank per device, valid with a command |
| dev_row | output | 104 | 13-bit row per device, valid with a command |
| lane_out | output | 64 | Write byte per device |
| lane_oe | output | 8 | Write lane enable per device |
| lane_in | input | 64 | Read byte per device |
| rsp_valid | output | 8 | Read byte valid per device |
| rsp_byte | output | 64 | Read byte per device |
| dev_idle | output | 8 | Device has no work |

## Verification
The hardest case to reach from the ports is a full per-device queue while the device is still busy with an earlier line, combined with a request for a different device arriving in the same cycle. To get there, the stimulus sends five back-to-back reads to one device. The first read takes the engine and the next four fill the queue. The port is then probed with an address for that device and an address for a neighbouring device. The same burst also yields precharge-to-activate gaps that must be exactly T_RP. After that, randomly placed traffic with random addresses and data mixes reads and writes across all devices so that their transfers overlap.

// File: rtl/lad_pkg.sv
package lad_pkg;

    localparam int NDEV       = 8;
    localparam int DEV_W      = $clog2(NDEV);
    localparam int LANE_W     = 8;
    localparam int LINE_BYTES = 64;
    localparam int LINE_W     = LINE_BYTES * LANE_W;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int BEAT_W     = $clog2(LINE_BYTES);
    localparam int BANK_W     = 2;
    localparam int ADDR_W     = 24;
    localparam int ROW_W      = ADDR_W - OFS_W - DEV_W - BANK_W;
    localparam int CMD_W      = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [LINE_W-1:0] data;
    } req_t;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } loc_t;

    function automatic loc_t split_addr(input logic [ADDR_W-1:OFS_W] a);
        loc_t l;
        l.dev  = a[OFS_W +: DEV_W];
        l.bank = a[OFS_W + DEV_W +: BANK_W];
        l.row  = a[ADDR_W-1 -: ROW_W];
        return l;
    endfunction

endpackage

// File: rtl/lad_queue.sv
module lad_queue
    import lad_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  req_t din,
    input  logic pop,
    output req_t dout,
    output logic full,
    output logic empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    req_t             mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/lad_engine.sv
module lad_engine
    import lad_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  req_t              q_head,
    output logic              q_pop,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [LANE_W-1:0] lane_out,
    output logic              lane_oe,
    input  logic [LANE_W-1:0] lane_in,
    output logic              rsp_valid,
    output logic [LANE_W-1:0] rsp_byte,
    output logic              busy
);
    localparam int MAXD  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int CNT_W = $clog2(MAXD + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_ACT, S_RCD, S_COL, S_XFER, S_PRE, S_RP
    } st_e;

    st_e               state;
    logic [CNT_W-1:0]  cnt;
    logic [BEAT_W-1:0] beat;
    req_t              cur;

    assign q_pop = !q_empty &&
                   ((state == S_IDLE) || (state == S_RP && cnt == '0));
    assign busy  = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            beat      <= '0;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= (state == S_XFER) && !cur.wr;
            rsp_byte  <= lane_in;
            case (state)
                S_IDLE: if (q_pop) begin
                    cur   <= q_head;
                    state <= S_ACT;
                end
                S_ACT: begin
                    cnt   <= CNT_W'(T_RCD - 2);
                    state <= S_RCD;
                end
                S_RCD: begin
                    if (cnt == '0) state <= S_COL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_COL: begin
                    beat  <= '0;
                    state <= S_XFER;
                end
                S_XFER: begin
                    if (beat == BEAT_W'(LINE_BYTES - 1)) state <= S_PRE;
                    else                                 beat  <= beat + 1'b1;
                end
                S_PRE: begin
                    cnt   <= CNT_W'(T_RP - 2);
                    state <= S_RP;
                end
                S_RP: begin
                    if (cnt == '0) begin
                        if (q_pop) begin
                            cur   <= q_head;
                            state <= S_ACT;
                        end else begin
                            state <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            S_ACT:   cmd = CMD_ACT;
            S_COL:   cmd = cur.wr ? CMD_WR : CMD_RD;
            S_PRE:   cmd = CMD_PRE;
            default: cmd = CMD_NOP;
        endcase
        cmd_bank = (cmd != CMD_NOP) ? cur.bank : '0;
        cmd_row  = (cmd != CMD_NOP) ? cur.row  : '0;
        lane_oe  = (state == S_XFER) && cur.wr;
        lane_out = lane_oe ? cur.data[beat*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/line_dispatch.sv
module line_dispatch
    import lad_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int T_RCD      = 3,
    parameter int T_RP       = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LINE_W-1:0]        req_wdata,
    output logic [NDEV*CMD_W-1:0]    dev_cmd,
    output logic [NDEV*BANK_W-1:0]   dev_bank,
    output logic [NDEV*ROW_W-1:0]    dev_row,
    output logic [NDEV*LANE_W-1:0]   lane_out,
    output logic [NDEV-1:0]          lane_oe,
    input  logic [NDEV*LANE_W-1:0]   lane_in,
    output logic [NDEV-1:0]          rsp_valid,
    output logic [NDEV*LANE_W-1:0]   rsp_byte,
    output logic [NDEV-1:0]          dev_idle
);
    loc_t           loc;
    req_t           in_req;
    logic [NDEV-1:0] q_full, q_empty, q_push, q_pop, eng_busy;
    logic           unused_ofs;

    assign unused_ofs = &{1'b0, req_addr[OFS_W-1:0]};
    assign loc        = split_addr(req_addr[ADDR_W-1:OFS_W]);
    assign req_ready  = !q_full[loc.dev];

    always_comb begin
        in_req.wr   = req_write;
        in_req.bank = loc.bank;
        in_req.row  = loc.row;
        in_req.data = req_wdata;
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        req_t head;
        cmd_e cmd;

        assign q_push[d] = req_valid && req_ready && (loc.dev == DEV_W'(d));

        lad_queue #(.DEPTH(FIFO_DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[d]),
            .din   (in_req),
            .pop   (q_pop[d]),
            .dout  (head),
            .full  (q_full[d]),
            .empty (q_empty[d])
        );

        lad_engine #(.T_RCD(T_RCD), .T_RP(T_RP)) u_eng (
            .clk       (clk),
            .rst       (rst),
            .q_empty   (q_empty[d]),
            .q_head    (head),
            .q_pop     (q_pop[d]),
            .cmd       (cmd),
            .cmd_bank  (dev_bank[d*BANK_W +: BANK_W]),
            .cmd_row   (dev_row[d*ROW_W +: ROW_W]),
            .lane_out  (lane_out[d*LANE_W +: LANE_W]),
            .lane_oe   (lane_oe[d]),
            .lane_in   (lane_in[d*LANE_W +: LANE_W]),
            .rsp_valid (rsp_valid[d]),
            .rsp_byte  (rsp_byte[d*LANE_W +: LANE_W]),
            .busy      (eng_busy[d])
        );

        assign dev_cmd[d*CMD_W +: CMD_W] = cmd;
        assign dev_idle[d] = !eng_busy[d] && q_empty[d];
    end
endmodule

// File: rtl/line_dispatch_chk.sv
module line_dispatch_chk
    import lad_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NDEV*CMD_W-1:0] dev_cmd,
    input logic [NDEV-1:0]       lane_oe,
    input logic [NDEV-1:0]       dev_idle
);
    for (genvar d = 0; d < NDEV; d++) begin : g_chk
        logic [CMD_W-1:0] c;
        logic [7:0] since_act, since_col, since_pre;

        assign c = dev_cmd[d*CMD_W +: CMD_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                since_act <= 8'hff;
                since_col <= 8'hff;
                since_pre <= 8'hff;
            end else begin
                since_act <= (c == CMD_ACT) ? 8'd1 : ((since_act == 8'hff) ? since_act : since_act + 8'd1);
                since_col <= (c == CMD_RD || c == CMD_WR) ? 8'd1 : ((since_col == 8'hff) ? since_col : since_col + 8'd1);
                since_pre <= (c == CMD_PRE) ? 8'd1 : ((since_pre == 8'hff) ? since_pre : since_pre + 8'd1);
            end
        end

        assert_col_delay_R3: assert property (@(posedge clk) disable iff (rst)
            (c == CMD_RD || c == CMD_WR) |-> (since_act == 8'(T_RCD)));

        assert_close_row_R7: assert property (@(posedge clk) disable iff (rst)
            (c == CMD_PRE) |-> (since_col == 8'(LINE_BYTES + 1)));

        assert_act_gap_R8: assert property (@(posedge clk) disable iff (rst)
            (c == CMD_ACT) |-> (since_pre >= 8'(T_RP)));

        assert_lane_quiet_R5: assert property (@(posedge clk) disable iff (rst)
            lane_oe[d] |-> (c == CMD_NOP));

        assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
            dev_idle[d] |-> (c == CMD_NOP && !lane_oe[d]));
    end
endmodule

bind line_dispatch line_dispatch_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dev_cmd  (dev_cmd),
    .lane_oe  (lane_oe),
    .dev_idle (dev_idle)
);

// File: tb/tb_line_dispatch.sv
module tb_line_dispatch;
    import lad_pkg::*;

    localparam int T_RCD = 3;
    localparam int T_RP  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LINE_W-1:0] req_wdata = '0;
    logic [NDEV*CMD_W-1:0] dev_cmd;
    logic [NDEV*BANK_W-1:0] dev_bank;
    logic [NDEV*ROW_W-1:0] dev_row;
    logic [NDEV*LANE_W-1:0] lane_out, rsp_byte;
    logic [NDEV*LANE_W-1:0] lane_in = '0;
    logic [NDEV-1:0] lane_oe, rsp_valid, dev_idle;

    line_dispatch #(.FIFO_DEPTH(4), .T_RCD(T_RCD), .T_RP(T_RP)) dut (.*);

    always #2 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;
    int stalls = 0, n_wr = 0, n_rd = 0, wr_beats = 0, rd_beats = 0, max_conc = 0;

    req_t q [NDEV][$];
    req_t cur [NDEV];
    int act_cyc [NDEV], col_cyc [NDEV], pre_cyc [NDEV];
    bit had_pre [NDEV], pend [NDEV], inflight [NDEV], post_pre [NDEV];
    int rpj [NDEV], wbeat [NDEV], rbeat [NDEV];
    bit dm_on [NDEV];
    int dm_beat [NDEV];
    logic [ROW_W-1:0] dm_row [NDEV];
    logic [CMD_W-1:0] mc;
    int conc;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] pat(input int d, input logic [ROW_W-1:0] row, input int k);
        return 8'(d * 37 + int'(row) * 5 + k * 3 + 1);
    endfunction

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] v;
        for (int i = 0; i < LINE_W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic send(input bit wr, input int dev, input logic [BANK_W-1:0] bank,
                        input logic [ROW_W-1:0] row, input logic [LINE_W-1:0] data);
        logic r;
        req_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {row, bank, DEV_W'(dev), OFS_W'($urandom)};
        req_wdata = data;
        forever begin
            #1 r = req_ready;
            @(posedge clk);
            if (r) break;
            stalls++;
            @(negedge clk);
        end
        e.wr = wr; e.bank = bank; e.row = row; e.data = data;
        q[dev].push_back(e);
        if (wr) n_wr++; else n_rd++;
        #1 req_valid = 1'b0;
    endtask

    // Device model and monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            conc = 0;
            for (int d = 0; d < NDEV; d++) begin
                mc = dev_cmd[d*CMD_W +: CMD_W];
                if (dm_on[d]) begin
                    lane_in[d*LANE_W +: LANE_W] = pat(d, dm_row[d], dm_beat[d]);
                    dm_beat[d]++;
                    if (dm_beat[d] == LINE_BYTES) dm_on[d] = 1'b0;
                end
                if (mc == CMD_ACT) dm_row[d] = dev_row[d*ROW_W +: ROW_W];
                if (mc == CMD_RD) begin dm_on[d] = 1'b1; dm_beat[d] = 0; end
                if (post_pre[d]) begin
                    rpj[d]++;
                    if (rpj[d] == T_RP) begin inflight[d] = 1'b0; post_pre[d] = 1'b0; end
                end
                case (mc)
                    CMD_NOP: ;
                    CMD_ACT: begin
                        chk(q[d].size() > 0, "R2 activate without request", d, 0);
                        if (q[d].size() > 0) begin
                            cur[d] = q[d].pop_front();
                            chk(dev_bank[d*BANK_W +: BANK_W] == cur[d].bank, "R1 bank",
                                dev_bank[d*BANK_W +: BANK_W], cur[d].bank);
                            chk(dev_row[d*ROW_W +: ROW_W] == cur[d].row, "R1 row",
                                dev_row[d*ROW_W +: ROW_W], cur[d].row);
                        end
                        if (had_pre[d]) begin
                            if (pend[d]) chk(cyc - pre_cyc[d] == T_RP, "R8 queued gap", cyc - pre_cyc[d], T_RP);
                            else         chk(cyc - pre_cyc[d] >= T_RP, "R8 min gap", cyc - pre_cyc[d], T_RP);
                        end
                        act_cyc[d] = cyc;
                        inflight[d] = 1'b1;
                    end
                    CMD_RD, CMD_WR: begin
                        chk(cyc - act_cyc[d] == T_RCD, "R3 act to column", cyc - act_cyc[d], T_RCD);
                        chk((mc == CMD_WR) == cur[d].wr, "R4 column type", mc, cur[d].wr ? 3 : 2);
                        col_cyc[d] = cyc;
                        wbeat[d] = 0;
                        rbeat[d] = 0;
                    end
                    CMD_PRE: begin
                        chk(cyc - col_cyc[d] == LINE_BYTES + 1, "R7 precharge time",
                            cyc - col_cyc[d], LINE_BYTES + 1);
                        chk(dev_row[d*ROW_W +: ROW_W] == cur[d].row &&
                            dev_bank[d*BANK_W +: BANK_W] == cur[d].bank, "R7 precharge row",
                            dev_row[d*ROW_W +: ROW_W], cur[d].row);
                        pre_cyc[d] = cyc;
                        had_pre[d] = 1'b1;
                        pend[d] = q[d].size() > 0;
                        post_pre[d] = 1'b1;
                        rpj[d] = 0;
                    end
                    default: chk(1'b0, "R2 command code", mc, 0);
                endcase
                if (lane_oe[d]) begin
                    chk(cur[d].wr && lane_out[d*LANE_W +: LANE_W] == cur[d].data[wbeat[d]*8 +: 8],
                        "R5 write byte", lane_out[d*LANE_W +: LANE_W], cur[d].data[wbeat[d]*8 +: 8]);
                    wbeat[d]++;
                    wr_beats++;
                    conc++;
                end
                if (rsp_valid[d]) begin
                    chk(!cur[d].wr && rsp_byte[d*LANE_W +: LANE_W] == pat(d, cur[d].row, rbeat[d]),
                        "R6 read byte", rsp_byte[d*LANE_W +: LANE_W], pat(d, cur[d].row, rbeat[d]));
                    rbeat[d]++;
                    rd_beats++;
                    conc++;
                end
                chk(dev_idle[d] == (!inflight[d] && q[d].size() == 0), "R11 idle flag",
                    dev_idle[d], !inflight[d] && q[d].size() == 0);
            end
            if (conc > max_conc) max_conc = conc;
        end
    end

    initial begin
        while (cyc < 150000 && !done) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int d = 0; d < NDEV; d++) begin
            inflight[d] = 0; post_pre[d] = 0; had_pre[d] = 0; dm_on[d] = 0;
            cur[d] = '0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(dev_idle == '1, "R11 reset idle", dev_idle, 8'hff);
        chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
        chk(dev_cmd == '0, "R11 reset cmd", dev_cmd, 0);
        chk(lane_oe == '0 && rsp_valid == '0, "R11 reset lanes", {lane_oe, rsp_valid}, 0);

        // R1 boundaries: top device, top bank, top row; then bottom
        send(1'b1, 7, 2'b11, '1, rand_line());
        send(1'b0, 0, 2'b00, '0, '0);
        repeat (90) @(negedge clk);

        // R9 / R8: five reads to device 0 fill its queue behind the running one
        for (int i = 0; i < 5; i++) send(1'b0, 0, BANK_W'(i), ROW_W'(i * 100 + 7), '0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = {ROW_W'(5), 2'b01, 3'd0, 6'd0};
        #1 chk(req_ready == 1'b0, "R9 full queue holds request", req_ready, 0);
        req_addr = {ROW_W'(5), 2'b01, 3'd1, 6'd0};
        #1 chk(req_ready == 1'b1, "R10 other device still ready", req_ready, 1);
        req_valid = 1'b0;
        // R10 concurrent devices
        send(1'b0, 2, 2'b01, 13'h0abc, '0);
        send(1'b1, 5, 2'b10, 13'h1234, rand_line());
        // a sixth to device 0 must wait, then be served
        send(1'b1, 0, 2'b11, 13'h0777, rand_line());

        // random traffic
        for (int i = 0; i < 60; i++) begin
            send(1'($urandom), int'($urandom % NDEV), BANK_W'($urandom), ROW_W'($urandom), rand_line());
            repeat ($urandom % 4) @(negedge clk);
        end

        while (dev_idle != '1) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        for (int d = 0; d < NDEV; d++)
            chk(q[d].size() == 0, "R9 all requests served", q[d].size(), 0);
        chk(stalls > 0, "R9 back-pressure seen", stalls, 1);
        chk(max_conc >= 2, "R10 parallel transfers", max_conc, 2);
        chk(wr_beats == n_wr * LINE_BYTES, "R5 write beat total", wr_beats, n_wr * LINE_BYTES);
        chk(rd_beats == n_rd * LINE_BYTES, "R6 read beat total", rd_beats, n_rd * LINE_BYTES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule